// File: doc/BRIEF.md
# Fetch and Branch Redirect Unit

This unit is the front end of a five-stage in-order pipeline. It holds the program counter and reads one 32-bit instruction per cycle from a byte-addressed instruction memory. The four bytes that come back are assembled into a big-endian word. The fetched word goes into the IF/ID pipeline register together with a valid bit and the sequential address (PC+4). Fetch always assumes that a branch falls through, so the PC moves on by four on every fetch.

The single conditional branch is resolved while it sits in IF/ID, which is the decode stage. The register file supplies the values of its two source registers. The branch is taken when those two values differ. In that case the redirect loads the branch target into the PC and writes a bubble over the slot that was fetched on the wrong path. The branch operands never depend on the two instructions just before the branch, so no forwarding into decode is needed.

A stall request from the hazard logic freezes both the PC and IF/ID. Once a halt instruction has been decoded, fetch stops for good and only bubbles follow the halt.

Top module: `fetch_redirect`

## Requirements
- R1: After a synchronous active-high reset, `imem_addr` (the PC) is 0, `ifid_valid` is 0 and `halted` is 0.
- R2: The fetched word is big-endian. Byte lane 0 of `imem_rdata` (bits 7:0) holds the byte at the PC and supplies instruction bits 31:24. Lane k holds the byte at PC+k and supplies bits 31-8k down to 24-8k.
- R3: In a cycle with no stall, no taken branch and no halt, the PC advances by 4. IF/ID then captures the fetched word with `ifid_valid`=1 and `ifid_pc4` = old PC + 4.
- R4: A valid IF/ID instruction with opcode 6'b000100 in bits 31:26 is a branch. Its source registers are in bits 25:21 and 20:16. When the two operand values differ, the next PC is `ifid_pc4` plus the sign-extended bits 15:0 shifted left by two.
- R5: On a taken branch, the next IF/ID content has `ifid_valid`=0, so exactly one wrong-path slot is squashed.
- R6: A branch whose two operand values are equal is not taken and fetch continues at PC+4.
- R7: When `ifid_valid` is 0, a branch or halt opcode in `ifid_instr` has no effect: `branch_taken` and `dec_halt` stay 0 and the PC advances normally.
- R8: While `stall` is 1, the PC, IF/ID and `halted` keep their values through the clock edge.
- R9: A valid IF/ID instruction with opcode 6'b111111 is a halt, and `dec_halt` is 1 while it is in decode. At the first unstalled edge, `halted` becomes 1. From then on the PC is frozen and `ifid_valid` stays 0 until reset.
- R10: `branch_taken` is 1 exactly when decode holds a valid branch whose operand values differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Hold request from the hazard logic |
| imem_addr | output | ADDR_W | Fetch byte address (the PC) |
| imem_rdata | input | 32 | Four byte lanes; lane k holds the byte at imem_addr+k |
| id_rs_val | input | 32 | Register value for the rs field of ifid_instr |
| id_rt_val | input | 32 | Register value for the rt field of ifid_instr |
| ifid_valid | output | 1 | IF/ID valid bit (0 = bubble) |
| ifid_instr | output | 32 | IF/ID instruction word |
| ifid_pc4 | output | ADDR_W | IF/ID sequential address |
| branch_taken | output | 1 | Decode redirects fetch this cycle |
| dec_halt | output | 1 | Decode holds a valid halt |
| halted | output | 1 | Fetch permanently stopped |

## Verification
The hardest case to reach from the ports is a branch opcode in the squashed slot behind a taken branch. That opcode is present in `ifid_instr` but has to be ignored. A close second is a stall that lands while a branch or halt waits in decode. The bench runs a fixed program that places a branch with unequal operands right behind a taken branch, and that also includes equal-operand branches, forward and backward targets, and a final halt. The program is run once without stalls and then under two stall patterns. One of those patterns stalls every other cycle, so a stall falls on each decode event. A cycle-by-cycle model built from the requirements predicts every output.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
    localparam int INSTR_W = 32;
    localparam int LANE_W  = 8;
    localparam int LANES   = INSTR_W / LANE_W;

    localparam logic [5:0] OP_BRANCH = 6'b000100;
    localparam logic [5:0] OP_HALT   = 6'b111111;

    typedef struct packed {
        logic [5:0]  op;
        logic [4:0]  rs;
        logic [4:0]  rt;
        logic [15:0] imm;
    } instr_t;

    typedef struct packed {
        logic is_branch;
        logic taken;
        logic is_halt;
    } dec_t;

    function automatic logic [31:0] br_offset(input logic [15:0] imm);
        return {{14{imm[15]}}, imm, 2'b00};
    endfunction
endpackage

// File: rtl/fetch_assemble.sv
module fetch_assemble
    import fetch_pkg::*;
(
    input  logic [INSTR_W-1:0] lanes,
    output logic [INSTR_W-1:0] word
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign word[INSTR_W-1-k*LANE_W -: LANE_W] = lanes[k*LANE_W +: LANE_W];
    end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
    import fetch_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic               valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  pc4,
    input  logic [31:0]        rs_val,
    input  logic [31:0]        rt_val,
    output dec_t               dec,
    output logic [ADDR_W-1:0]  target
);
    instr_t     f;
    logic [31:0] off;

    always_comb begin
        f             = instr_t'(instr);
        off           = br_offset(f.imm);
        dec.is_branch = valid && (f.op == OP_BRANCH);
        dec.taken     = dec.is_branch && (rs_val != rt_val);
        dec.is_halt   = valid && (f.op == OP_HALT);
        target        = pc4 + off[ADDR_W-1:0];
    end
endmodule

// File: rtl/pc_unit.sv
module pc_unit #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              halt_now,
    input  logic              taken,
    input  logic [ADDR_W-1:0] target,
    input  logic [ADDR_W-1:0] seq_pc,
    output logic [ADDR_W-1:0] pc,
    output logic              halted
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pc     <= '0;
            halted <= 1'b0;
        end else if (!stall) begin
            if (halted || halt_now) begin
                halted <= 1'b1;
            end else if (taken) begin
                pc <= target;
            end else begin
                pc <= seq_pc;
            end
        end
    end
endmodule

// File: rtl/ifid_reg.sv
module ifid_reg
    import fetch_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stall,
    input  logic               squash,
    input  logic [INSTR_W-1:0] word_in,
    input  logic [ADDR_W-1:0]  pc4_in,
    output logic               valid,
    output logic [INSTR_W-1:0] word,
    output logic [ADDR_W-1:0]  pc4
);
    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            word  <= '0;
            pc4   <= '0;
        end else if (!stall) begin
            valid <= !squash;
            word  <= word_in;
            pc4   <= pc4_in;
        end
    end
endmodule

// File: rtl/fetch_redirect.sv
module fetch_redirect
    import fetch_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    output logic [ADDR_W-1:0] imem_addr,
    input  logic [31:0]       imem_rdata,
    input  logic [31:0]       id_rs_val,
    input  logic [31:0]       id_rt_val,
    output logic              ifid_valid,
    output logic [31:0]       ifid_instr,
    output logic [ADDR_W-1:0] ifid_pc4,
    output logic              branch_taken,
    output logic              dec_halt,
    output logic              halted
);
    localparam int STEP = INSTR_W / LANE_W;

    logic [INSTR_W-1:0] fetch_word;
    logic [ADDR_W-1:0]  seq_pc;
    logic [ADDR_W-1:0]  target;
    dec_t               dec;

    assign seq_pc = imem_addr + ADDR_W'(STEP);

    fetch_assemble u_asm (
        .lanes (imem_rdata),
        .word  (fetch_word)
    );

    branch_resolve #(.ADDR_W(ADDR_W)) u_br (
        .valid  (ifid_valid),
        .instr  (ifid_instr),
        .pc4    (ifid_pc4),
        .rs_val (id_rs_val),
        .rt_val (id_rt_val),
        .dec    (dec),
        .target (target)
    );

    pc_unit #(.ADDR_W(ADDR_W)) u_pc (
        .clk      (clk),
        .rst      (rst),
        .stall    (stall),
        .halt_now (dec.is_halt),
        .taken    (dec.taken),
        .target   (target),
        .seq_pc   (seq_pc),
        .pc       (imem_addr),
        .halted   (halted)
    );

    ifid_reg #(.ADDR_W(ADDR_W)) u_ifid (
        .clk     (clk),
        .rst     (rst),
        .stall   (stall),
        .squash  (dec.taken || dec.is_halt || halted),
        .word_in (fetch_word),
        .pc4_in  (seq_pc),
        .valid   (ifid_valid),
        .word    (ifid_instr),
        .pc4     (ifid_pc4)
    );

    assign branch_taken = dec.taken;
    assign dec_halt     = dec.is_halt;
endmodule

// File: rtl/fetch_redirect_chk.sv
module fetch_redirect_chk
    import fetch_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              stall,
    input logic [ADDR_W-1:0] imem_addr,
    input logic              ifid_valid,
    input logic [31:0]       ifid_instr,
    input logic [ADDR_W-1:0] ifid_pc4,
    input logic              branch_taken,
    input logic              dec_halt,
    input logic              halted
);
    a_r1_reset_state: assert property (@(posedge clk)
        $past(rst) |-> (imem_addr == '0 && !ifid_valid && !halted));

    a_r3_seq_advance: assert property (@(posedge clk) disable iff (rst)
        (!stall && !halted && !branch_taken && !dec_halt)
        |=> imem_addr == $past(imem_addr) + ADDR_W'(4));

    a_r4_target: assert property (@(posedge clk) disable iff (rst)
        (branch_taken && !stall)
        |=> imem_addr == $past(ifid_pc4 + br_offset(ifid_instr[15:0])[ADDR_W-1:0]));

    a_r5_squash: assert property (@(posedge clk) disable iff (rst)
        (branch_taken && !stall) |=> !ifid_valid);

    a_r7_bubble_inert: assert property (@(posedge clk) disable iff (rst)
        !ifid_valid |-> (!branch_taken && !dec_halt));

    a_r8_stall_hold: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(imem_addr) && $stable(ifid_valid) && $stable(ifid_instr)
                   && $stable(halted)));

    a_r9_halt_freeze: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(imem_addr)));

    a_r9_halt_bubbles: assert property (@(posedge clk) disable iff (rst)
        halted |-> !ifid_valid);
endmodule

bind fetch_redirect fetch_redirect_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .stall        (stall),
    .imem_addr    (imem_addr),
    .ifid_valid   (ifid_valid),
    .ifid_instr   (ifid_instr),
    .ifid_pc4     (ifid_pc4),
    .branch_taken (branch_taken),
    .dec_halt     (dec_halt),
    .halted       (halted)
);

// File: tb/fetch_redirect_bench.sv
module fetch_redirect_bench;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          stall = 1'b0;
    logic [AW-1:0] imem_addr;
    logic [31:0]   imem_rdata;
    logic [31:0]   id_rs_val;
    logic [31:0]   id_rt_val;
    logic          ifid_valid;
    logic [31:0]   ifid_instr;
    logic [AW-1:0] ifid_pc4;
    logic          branch_taken;
    logic          dec_halt;
    logic          halted;

    int checks = 0;
    int errors = 0;

    logic [7:0]  mem [256];
    logic [31:0] prog [64];

    always #4 clk = ~clk;

    fetch_redirect #(.ADDR_W(AW)) u_fetch_redirect (
        .clk(clk), .rst(rst), .stall(stall),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .id_rs_val(id_rs_val), .id_rt_val(id_rt_val),
        .ifid_valid(ifid_valid), .ifid_instr(ifid_instr), .ifid_pc4(ifid_pc4),
        .branch_taken(branch_taken), .dec_halt(dec_halt), .halted(halted)
    );

    function automatic logic [31:0] regval(input logic [4:0] idx);
        return 32'h01010101 * {27'b0, idx};
    endfunction

    always_comb begin
        for (int k = 0; k < 4; k++)
            imem_rdata[k*8 +: 8] = mem[8'(imem_addr[7:0] + 8'(k))];
        id_rs_val = regval(ifid_instr[25:21]);
        id_rt_val = regval(ifid_instr[20:16]);
    end

    function automatic logic [31:0] enc(input int op, input int rs, input int rt, input int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic build_prog();
        for (int w = 0; w < 64; w++) prog[w] = enc(8, w % 32, (w * 3) % 32, w * 37);
        prog[1]  = enc(4, 1, 1, 5);    // R6 equal operands
        prog[2]  = enc(4, 2, 3, 3);    // R4 forward to word 6
        prog[3]  = enc(4, 4, 5, -3);   // R7 squashed branch, must be ignored
        prog[7]  = enc(4, 7, 8, 10);   // R4 to word 18
        prog[18] = enc(4, 9, 9, 2);    // R6
        prog[19] = enc(4, 1, 2, 10);   // R4 to word 30
        prog[26] = enc(4, 1, 2, 13);   // R4 to word 40
        prog[30] = enc(4, 3, 6, -5);   // R4 backward to word 26
        prog[31] = enc(63, 0, 0, 0);   // R7 squashed halt
        prog[45] = enc(63, 0, 0, 0);   // R9 halt
        for (int w = 0; w < 64; w++) begin
            mem[4*w]   = prog[w][31:24];
            mem[4*w+1] = prog[w][23:16];
            mem[4*w+2] = prog[w][15:8];
            mem[4*w+3] = prog[w][7:0];
        end
    endtask

    task automatic run_pass(input int mode);
        logic [AW-1:0] m_pc, m_pc4;
        logic          m_v, m_h, m_taken, m_hlt, st;
        logic [31:0]   m_ins;
        logic [5:0]    op;
        string         kind;
        int            after;
        rst = 1'b1; stall = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 pc", 32'(imem_addr), 32'h0);
        chk("R1 valid", 32'(ifid_valid), 32'h0);
        chk("R1 halted", 32'(halted), 32'h0);
        m_pc = '0; m_v = 1'b0; m_h = 1'b0; m_ins = '0; m_pc4 = '0;
        kind = "R1"; after = 0;
        for (int cyc = 0; cyc < 400 && after < 8; cyc++) begin
            op      = m_ins[31:26];
            m_taken = m_v && op == 6'd4 && regval(m_ins[25:21]) != regval(m_ins[20:16]);
            m_hlt   = m_v && op == 6'd63;
            chk({kind, " pc"}, 32'(imem_addr), 32'(m_pc));
            chk(kind == "R4" ? "R5 valid" : {kind, " valid"}, 32'(ifid_valid), 32'(m_v));
            if (m_v) begin
                chk("R2 instr", ifid_instr, m_ins);
                chk("R3 pc4", 32'(ifid_pc4), 32'(m_pc4));
            end
            if (!m_v && (op == 6'd4 || op == 6'd63)) begin
                chk("R7 taken", 32'(branch_taken), 32'h0);
                chk("R7 halt", 32'(dec_halt), 32'h0);
            end else begin
                chk(m_v && op == 6'd4 && !m_taken ? "R6 taken" : "R10 taken",
                    32'(branch_taken), 32'(m_taken));
                chk("R9 dec_halt", 32'(dec_halt), 32'(m_hlt));
            end
            chk("R9 halted", 32'(halted), 32'(m_h));
            case (mode)
                1:       st = (cyc % 7 == 2) || (cyc % 11 == 5);
                2:       st = (cyc % 2 == 1);
                default: st = 1'b0;
            endcase
            stall = st;
            if (st) begin
                kind = "R8";
            end else if (m_h || m_hlt) begin
                m_h = 1'b1; m_v = 1'b0; kind = "R9";
            end else if (m_taken) begin
                m_pc = m_pc4 + 16'({{14{m_ins[15]}}, m_ins[15:0], 2'b00});
                m_v = 1'b0; kind = "R4";
            end else begin
                m_ins = prog[m_pc[7:2]];
                m_pc4 = m_pc + 16'd4;
                m_pc  = m_pc4;
                m_v = 1'b1; kind = "R3";
            end
            if (m_h) after++;
            @(posedge clk);
            @(negedge clk);
        end
        chk("R9 reached halt", 32'(m_h), 32'h1);
        stall = 1'b0;
    endtask

    initial begin
        build_prog();
        for (int mode = 0; mode < 3; mode++) run_pass(mode);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R3 actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule